// File: doc/BRIEF.md
# Line-Card Power-Mode and Status Sequencer

This block sequences power and status reporting for a four-channel voice line interface. It tracks a frame-sync strobe against a control-clock cycle count. It keeps one global full-powerdown state and a per-channel standby mask, and it drives one active-low enable strobe per channel. Each strobe fires once per frame, and the channels take their turns in a fixed round-robin order.

While the block is out of full powerdown, every channel's enable pulse runs freely in each frame, including channels held in standby. Full powerdown is entered on reset, or when frame sync has been missing for a set number of frame periods. Only a frame-sync strobe ends it. In full powerdown all enables stay high, and every channel reports itself off, whatever its standby bit says.

On the clock edge that ends each enable pulse, the block latches a two-bit status pair (line supervision and thermal shutdown, both active-low) from a shared input. A host chip-select returns an eight-bit word built from those pairs. A channel that has not been refreshed since the previous read reads as zeros. A small parallel write port holds the standby mask, relay-driver bits, per-channel mode bits, the receive-gain code and the time-slot map, each with its power-up default.

Top module: `linecard_pwr_ctl`

## Requirements
- R1: After reset, pd_o is 1, all en_n_o bits are 1 and all chan_off_o bits are 1. While pd_o is 1, no en_n_o bit ever goes low.
- R2: After reset, tslot_o field n (bits n*TS_W upward, TS_W wide) holds n, relay_o and mode_o are all zeros, and rx_gain_o is 7. The gain code counts attenuation in 0.5 dB steps, so 7 means -3.5 dB.
- R3: A clock edge that samples fsync_i high clears powerdown, and pd_o reads 0 in the cycle after that edge. Nothing else clears pd_o.
- R4: Take the cycle that begins at a frame-start edge as cycle 0. A frame starts at a sync edge, or every FRAME_CYC cycles after one. Outside powerdown, channel k's enable is low for exactly one cycle, cycle EN_BASE + k*EN_STEP + 1, and is high in every other cycle of the frame.
- R5: If no fsync_i is sampled for LOSS_FRAMES consecutive frame periods, pd_o rises at the edge LOSS_FRAMES*FRAME_CYC cycles after the last sync edge. A sync every FRAME_CYC cycles keeps pd_o at 0.
- R6: Outside powerdown, enable pulses keep running in frames that have no sync, and they run for channels in standby as well.
- R7: Write address 0, bits [NCH-1:0], is the standby mask. chan_off_o[n] is 1 when pd_o is 1 or standby bit n is 1, so powerdown overrides the mask.
- R8: At the edge that ends channel n's enable pulse, sts_i is captured: sts_i[1] is supervision and sts_i[0] is thermal shutdown. In the read word, bit 2*NCH-1-2n carries channel n's supervision and bit 2*NCH-2-2n carries its thermal bit.
- R9: An edge that samples cs_i high loads rd_word_o, visible in the next cycle. rd_word_o holds its value at all other times. A channel with no capture since the previous read reads 00. The value of the first read after reset is unspecified.
- R10: Address 1 writes relay_o, address 2 writes mode_o, address 3 writes rx_gain_o and address 4+n writes time-slot field n. Writes to addresses 4+NCH and above change no output.
- R11: When a capture and a chip-select fall on the same edge, the read returns the word as it stood before that capture, and the new capture stays fresh for the following read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_i | input | 1 | Frame-sync strobe, one cycle |
| cs_i | input | 1 | Host chip-select, one cycle per read |
| sts_i | input | 2 | Shared status pair from the enabled channel (supervision, thermal), active-low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| en_n_o | output | NCH | Active-low per-channel enable strobes |
| pd_o | output | 1 | Global full-powerdown state |
| chan_off_o | output | NCH | Per-channel powered-off indication |
| rd_word_o | output | 2*NCH | Status word returned by the last chip-select |
| tslot_o | output | NCH*TS_W | Time-slot map, one field per channel |
| relay_o | output | NCH*RLY_W | Relay-driver control bits |
| mode_o | output | NCH*MODE_W | Per-channel mode bits |
| rx_gain_o | output | GAIN_W | Receive-gain attenuation code |

## Verification
The bench counts cycles from each frame-start edge. pd_o leaves powerdown one cycle after the sync edge. Channel k's enable is low in cycle EN_BASE+k*EN_STEP+1, and the status driven during that same cycle is what gets latched. A read result appears one cycle after its chip-select edge, and powerdown returns exactly LOSS_FRAMES*FRAME_CYC edges after the last sync. Inputs are driven and outputs sampled at the falling clock edge. Each frame's expected enable pattern, capture set and read words are computed by bench functions, cycle by cycle, before the rising edge they depend on.

// File: rtl/lcp_pkg.sv
package lcp_pkg;

  // cycle of the frame position counter at which channel ch is strobed
  function automatic int pulse_pos(int ch, int base, int step);
    return base + ch * step;
  endfunction

  // attenuation given in tenths of a dB, converted to 0.5 dB steps
  function automatic int half_db_steps(int tenths);
    return tenths / 5;
  endfunction

  function automatic int width_for(int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // read-word bit positions of a channel's supervision and thermal bits
  function automatic int sup_bit(int ch, int nch);
    return 2 * nch - 1 - 2 * ch;
  endfunction

  function automatic int thr_bit(int ch, int nch);
    return 2 * nch - 2 - 2 * ch;
  endfunction

endpackage

// File: rtl/lcp_frame_watch.sv
module lcp_frame_watch import lcp_pkg::*; #(
  parameter int FRAME_CYC   = 16,
  parameter int LOSS_FRAMES = 4,
  localparam int POS_W      = width_for(FRAME_CYC),
  localparam int MISS_W     = width_for(LOSS_FRAMES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync_i,
  output logic [POS_W-1:0] pos_o,
  output logic             pd_o
);

  logic [POS_W-1:0]  pos_q;
  logic [MISS_W-1:0] miss_q;
  logic              pd_q;
  logic              frame_end;
  logic              miss_sat;
  logic              last_miss;

  assign frame_end = (pos_q == POS_W'(FRAME_CYC - 1));
  assign miss_sat  = (miss_q == MISS_W'(LOSS_FRAMES));
  assign last_miss = (miss_q == MISS_W'(LOSS_FRAMES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      miss_q <= MISS_W'(LOSS_FRAMES);
      pd_q   <= 1'b1;
    end else if (fsync_i) begin
      pos_q  <= '0;
      miss_q <= '0;
      pd_q   <= 1'b0;
    end else if (frame_end) begin
      pos_q <= '0;
      if (!miss_sat) miss_q <= miss_q + 1'b1;
      if (last_miss) pd_q <= 1'b1;
    end else begin
      pos_q <= pos_q + 1'b1;
    end
  end

  assign pos_o = pos_q;
  assign pd_o  = pd_q;

  // R5
  miss_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_q <= MISS_W'(LOSS_FRAMES));

  // R5
  pd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_q) |-> miss_sat);

  // R3
  sync_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_i |=> !pd_q);

  // R3
  wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_q) |-> $past(fsync_i));

endmodule

// File: rtl/lcp_en_sched.sv
module lcp_en_sched import lcp_pkg::*; #(
  parameter int NCH     = 4,
  parameter int POS_W   = 4,
  parameter int EN_BASE = 2,
  parameter int EN_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] pos_i,
  input  logic             pd_i,
  output logic [NCH-1:0]   en_n_o
);

  logic [NCH-1:0] hit;
  logic [NCH-1:0] en_n_q;

  for (genvar k = 0; k < NCH; k++) begin : g_hit
    assign hit[k] = (pos_i == POS_W'(pulse_pos(k, EN_BASE, EN_STEP)));

    // R4
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_n_q[k] |=> en_n_q[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_n_q <= '1;
    else        en_n_q <= ~(hit & {NCH{~pd_i}});
  end

  assign en_n_o = en_n_q;

  // R1
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_i |=> (&en_n_q));

  // R4
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~en_n_q));

endmodule

// File: rtl/lcp_status_cap.sv
module lcp_status_cap import lcp_pkg::*; #(
  parameter int NCH = 4,
  localparam int WW = 2 * NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] en_n_i,
  input  logic [1:0]     sts_i,
  input  logic           cs_i,
  output logic [WW-1:0]  rd_word_o
);

  logic [NCH-1:0]       cap_evt;
  logic [NCH-1:0][1:0]  cap_q;
  logic [NCH-1:0]       fresh_q;
  logic [WW-1:0]        word_now;
  logic [WW-1:0]        rd_q;

  assign cap_evt = ~en_n_i;

  always_comb begin
    word_now = '0;
    for (int n = 0; n < NCH; n++) begin
      word_now[sup_bit(n, NCH)] = fresh_q[n] & cap_q[n][1];
      word_now[thr_bit(n, NCH)] = fresh_q[n] & cap_q[n][0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= '0;
      fresh_q <= '0;
      rd_q    <= '0;
    end else begin
      if (cs_i) rd_q <= word_now;
      for (int n = 0; n < NCH; n++) begin
        if (cap_evt[n]) begin
          cap_q[n]   <= sts_i;
          fresh_q[n] <= 1'b1;
        end else if (cs_i) begin
          fresh_q[n] <= 1'b0;
        end
      end
    end
  end

  assign rd_word_o = rd_q;

  // R9
  cs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_i |=> ((fresh_q & ~$past(cap_evt)) == '0));

  // R8
  capture_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cap_evt) |=> ((fresh_q & $past(cap_evt)) == $past(cap_evt)));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |=> $stable(rd_q));

endmodule

// File: rtl/lcp_cfg_regs.sv
module lcp_cfg_regs import lcp_pkg::*; #(
  parameter int NCH        = 4,
  parameter int TS_W       = 5,
  parameter int RLY_W      = 2,
  parameter int MODE_W     = 2,
  parameter int GAIN_W     = 4,
  parameter int ATT_TENTHS = 35,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  localparam int RLY_TOT   = NCH * RLY_W,
  localparam int MODE_TOT  = NCH * MODE_W,
  localparam int TS_BASE   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  output logic [NCH-1:0]        stby_o,
  output logic [NCH*TS_W-1:0]   tslot_o,
  output logic [RLY_TOT-1:0]    relay_o,
  output logic [MODE_TOT-1:0]   mode_o,
  output logic [GAIN_W-1:0]     gain_o
);

  localparam logic [GAIN_W-1:0] GAIN_RST = GAIN_W'(half_db_steps(ATT_TENTHS));

  logic [NCH-1:0]            stby_q;
  logic [NCH-1:0][TS_W-1:0]  ts_q;
  logic [RLY_TOT-1:0]        relay_q;
  logic [MODE_TOT-1:0]       mode_q;
  logic [GAIN_W-1:0]         gain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stby_q  <= '0;
      relay_q <= '0;
      mode_q  <= '0;
      gain_q  <= GAIN_RST;
      for (int n = 0; n < NCH; n++) ts_q[n] <= TS_W'(n);
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_W'(0)) stby_q  <= wr_data_i[NCH-1:0];
      if (wr_addr_i == ADDR_W'(1)) relay_q <= wr_data_i[RLY_TOT-1:0];
      if (wr_addr_i == ADDR_W'(2)) mode_q  <= wr_data_i[MODE_TOT-1:0];
      if (wr_addr_i == ADDR_W'(3)) gain_q  <= wr_data_i[GAIN_W-1:0];
      for (int n = 0; n < NCH; n++)
        if (wr_addr_i == ADDR_W'(TS_BASE + n)) ts_q[n] <= wr_data_i[TS_W-1:0];
    end
  end

  assign stby_o  = stby_q;
  assign tslot_o = ts_q;
  assign relay_o = relay_q;
  assign mode_o  = mode_q;
  assign gain_o  = gain_q;

  // R10
  ignored_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (wr_addr_i >= ADDR_W'(TS_BASE + NCH))) |=>
      ($stable(stby_q) && $stable(ts_q) && $stable(relay_q) &&
       $stable(mode_q) && $stable(gain_q)));

endmodule

// File: rtl/linecard_pwr_ctl.sv
module linecard_pwr_ctl import lcp_pkg::*; #(
  parameter int NCH         = 4,
  parameter int FRAME_CYC   = 16,
  parameter int LOSS_FRAMES = 4,
  parameter int EN_BASE     = 2,
  parameter int EN_STEP     = 2,
  parameter int TS_W        = 5,
  parameter int RLY_W       = 2,
  parameter int MODE_W      = 2,
  parameter int GAIN_W      = 4,
  parameter int ATT_TENTHS  = 35,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  localparam int POS_W      = width_for(FRAME_CYC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fsync_i,
  input  logic                     cs_i,
  input  logic [1:0]               sts_i,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  output logic [NCH-1:0]           en_n_o,
  output logic                     pd_o,
  output logic [NCH-1:0]           chan_off_o,
  output logic [2*NCH-1:0]         rd_word_o,
  output logic [NCH*TS_W-1:0]      tslot_o,
  output logic [NCH*RLY_W-1:0]     relay_o,
  output logic [NCH*MODE_W-1:0]    mode_o,
  output logic [GAIN_W-1:0]        rx_gain_o
);

  logic [POS_W-1:0] frame_pos;
  logic             pd_state;
  logic [NCH-1:0]   en_n;
  logic [NCH-1:0]   stby;

  lcp_frame_watch #(
    .FRAME_CYC  (FRAME_CYC),
    .LOSS_FRAMES(LOSS_FRAMES)
  ) u_watch (
    .clk    (clk),
    .rst_n  (rst_n),
    .fsync_i(fsync_i),
    .pos_o  (frame_pos),
    .pd_o   (pd_state)
  );

  lcp_en_sched #(
    .NCH    (NCH),
    .POS_W  (POS_W),
    .EN_BASE(EN_BASE),
    .EN_STEP(EN_STEP)
  ) u_sched (
    .clk   (clk),
    .rst_n (rst_n),
    .pos_i (frame_pos),
    .pd_i  (pd_state),
    .en_n_o(en_n)
  );

  lcp_status_cap #(
    .NCH(NCH)
  ) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_n_i   (en_n),
    .sts_i    (sts_i),
    .cs_i     (cs_i),
    .rd_word_o(rd_word_o)
  );

  lcp_cfg_regs #(
    .NCH       (NCH),
    .TS_W      (TS_W),
    .RLY_W     (RLY_W),
    .MODE_W    (MODE_W),
    .GAIN_W    (GAIN_W),
    .ATT_TENTHS(ATT_TENTHS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .stby_o   (stby),
    .tslot_o  (tslot_o),
    .relay_o  (relay_o),
    .mode_o   (mode_o),
    .gain_o   (rx_gain_o)
  );

  assign en_n_o     = en_n;
  assign pd_o       = pd_state;
  assign chan_off_o = stby | {NCH{pd_state}};

endmodule

// File: tb/linecard_pwr_ctl_test.sv
module linecard_pwr_ctl_test;
  localparam int NCH = 4, FRAME_CYC = 16, LOSS = 4, EN_BASE = 2, EN_STEP = 2;
  localparam int TS_W = 5, RLY_W = 2, MODE_W = 2, GAIN_W = 4, ADDR_W = 4, DATA_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, fsync = 1'b0, cs = 1'b0, wr_en = 1'b0;
  logic [1:0] sts = '0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [NCH-1:0] en_n, chan_off;
  logic pd;
  logic [2*NCH-1:0] rd_word;
  logic [NCH*TS_W-1:0] tslot;
  logic [NCH*RLY_W-1:0] relay;
  logic [NCH*MODE_W-1:0] mode;
  logic [GAIN_W-1:0] gain;

  linecard_pwr_ctl uut (
    .clk(clk), .rst_n(rst_n), .fsync_i(fsync), .cs_i(cs), .sts_i(sts),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .en_n_o(en_n), .pd_o(pd), .chan_off_o(chan_off), .rd_word_o(rd_word),
    .tslot_o(tslot), .relay_o(relay), .mode_o(mode), .rx_gain_o(gain));

  always #4 clk = ~clk;

  int tests = 0, fails = 0, reads = 0, since = 0;
  bit exp_pd = 1'b1;
  logic [NCH-1:0] stby_exp = '0;
  logic [1:0] exp_cap [NCH];
  bit exp_fresh [NCH];
  logic [2*NCH-1:0] last_read = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] exp_en(int c, bit pdx);
    logic [NCH-1:0] r;
    for (int k = 0; k < NCH; k++) r[k] = pdx || (c != EN_BASE + EN_STEP * k + 1);
    return r;
  endfunction

  function automatic logic [2*NCH-1:0] exp_word();
    logic [2*NCH-1:0] w = '0;
    for (int ch = 0; ch < NCH; ch++)
      if (exp_fresh[ch]) begin
        w[2*NCH-1-2*ch] = exp_cap[ch][1];
        w[2*NCH-2-2*ch] = exp_cap[ch][0];
      end
    return w;
  endfunction

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_check(input string tag, input logic [2*NCH-1:0] e);
    if (reads == 0) last_read = rd_word;   // first read after reset is unspecified
    else begin chk(tag, rd_word, e); last_read = e; end
    reads++;
  endtask

  task automatic start_sync();
    fsync = 1'b1;
    @(negedge clk);
    fsync = 1'b0; since = 0; exp_pd = 1'b0;
  endtask

  task automatic run_frame(input bit next_sync, input int force_cs);
    int bad_c = -1;
    logic [NCH-1:0] bad_act = '0, bad_exp = '0;
    for (int c = 0; c < FRAME_CYC; c++) begin
      logic [1:0] v;
      bit do_cs;
      logic [2*NCH-1:0] rexp;
      logic [NCH-1:0] capn = '0;
      if (c == 0) begin
        chk("R3 R5 pd at frame start", 32'(pd), 32'(exp_pd));
        chk("R7 chan_off", 32'(chan_off), exp_pd ? 32'hF : 32'(stby_exp));
        chk("R9 read word held", 32'(rd_word), 32'(last_read));
      end
      if (c == FRAME_CYC - 1) chk("R5 pd at frame end", 32'(pd), 32'(exp_pd));
      if (bad_c < 0 && en_n !== exp_en(c, exp_pd)) begin
        bad_c = c; bad_act = en_n; bad_exp = exp_en(c, exp_pd);
      end
      v = 2'($urandom);
      sts = v;
      do_cs = (c == force_cs) || ($urandom % 5 == 0);
      rexp = exp_word();
      for (int k = 0; k < NCH; k++)
        if (!exp_pd && c == EN_BASE + EN_STEP * k + 1) begin exp_cap[k] = v; capn[k] = 1'b1; end
      for (int k = 0; k < NCH; k++)
        if (capn[k]) exp_fresh[k] = 1'b1;
        else if (do_cs) exp_fresh[k] = 1'b0;
      cs = do_cs;
      if (c == FRAME_CYC - 1) fsync = next_sync;
      @(negedge clk);
      cs = 1'b0; fsync = 1'b0;
      if (do_cs) read_check((c == force_cs) ? "R11 same-edge read" : "R8 R9 status read", rexp);
    end
    tests++;
    if (bad_c >= 0) begin
      fails++;
      $display("FAIL R4 R6 enable pattern cycle %0d actual=%0h expected=%0h", bad_c, bad_act, bad_exp);
    end
    if (next_sync) begin since = 0; exp_pd = 1'b0; end
    else begin since++; if (since >= LOSS) exp_pd = 1'b1; end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    bit idle_bad = 1'b0;
    void'($urandom(32'd7321));
    for (int k = 0; k < NCH; k++) begin exp_cap[k] = '0; exp_fresh[k] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pd after reset", 32'(pd), 32'd1);
    chk("R1 enables after reset", 32'(en_n), 32'hF);
    chk("R1 chan_off after reset", 32'(chan_off), 32'hF);
    for (int n = 0; n < NCH; n++) chk("R2 tslot default", 32'(tslot[n*TS_W +: TS_W]), 32'(n));
    chk("R2 relay default", 32'(relay), 32'd0);
    chk("R2 mode default", 32'(mode), 32'd0);
    chk("R2 gain default", 32'(gain), 32'd7);

    for (int i = 0; i < 40; i++) begin
      if (en_n !== '1 || pd !== 1'b1) idle_bad = 1'b1;
      @(negedge clk);
    end
    chk("R1 R3 idle without sync", 32'(idle_bad), 32'd0);

    wr(0, 8'h05); stby_exp = 4'h5;
    chk("R7 powerdown overrides standby", 32'(chan_off), 32'hF);
    wr(1, 8'hA5); wr(2, 8'h3C); wr(3, 8'h09); wr(6, 8'd17);
    chk("R10 relay write", 32'(relay), 32'hA5);
    chk("R10 mode write", 32'(mode), 32'h3C);
    chk("R10 gain write", 32'(gain), 32'h9);
    chk("R10 tslot write", 32'(tslot[2*TS_W +: TS_W]), 32'd17);
    wr(9, 8'hFF); wr(15, 8'h00);
    chk("R10 ignored address", {relay, mode, 4'(gain), 8'(tslot[2*TS_W +: TS_W])},
        {8'hA5, 8'h3C, 4'h9, 8'd17});
    chk("R10 ignored address standby", 32'(chan_off), 32'hF);

    cs = 1'b1; @(negedge clk); cs = 1'b0; read_check("R9 first read", '0);
    cs = 1'b1; @(negedge clk); cs = 1'b0; read_check("R9 read before any capture", '0);

    start_sync();
    for (int f = 0; f < 6; f++) run_frame(1'b1, (f == 2) ? EN_BASE + EN_STEP + 1 : -1);
    for (int f = 0; f < 6; f++) run_frame(1'b0, -1);
    wr(0, 8'h0A); stby_exp = 4'hA;
    start_sync();
    for (int f = 0; f < 4; f++) run_frame(1'b1, (f == 1) ? EN_BASE + 3 * EN_STEP + 1 : -1);
    run_frame(1'b0, -1);
    summary();
  end
endmodule